// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This controller owns the operating mode of a packet radio. It takes host commands and status events from the physical layer and walks the device through its power and activity modes. From sleep it starts the crystal oscillator, then the frequency synthesizer, then a loop calibration, and settles in idle. From idle the host starts a transmission or a reception, or sends the device back to sleep.

While receiving, the controller follows the frame through four sub-phases: preamble hunt, delimiter search, header decode and payload. When a transmission or a reception ends, the controller can drop straight into light or deep sleep. It does so only when configured to and when no host interrupt is waiting. Each completion raises a one-cycle done pulse with a cause code.

The oscillator, synthesizer and calibration enables follow directly from the mode. The timed phases are counted in clock cycles set by parameters.

Top module: `radio_mode_seq`

## Requirements
- R1: Reset leaves the block in light sleep with every enable and pulse low. Mode codes: 0 light sleep, 1 deep sleep, 2 oscillator start, 3 synthesizer start, 4 calibration, 5 idle, 6 transmit, 7 receive. `osc_en` is high outside both sleeps, `synth_en` is high in modes 3 to 7, and `cal_en` is high only in mode 4.
- R2: `cmd_wake` in either sleep mode gives oscillator start for exactly WAKE_CYCLES cycles, then synthesizer start for SYNTH_CYCLES cycles, then calibration for CAL_CYCLES cycles, then idle.
- R3: In idle with a valid calibration, `cmd_tx` enters transmit on the next cycle and `cmd_rx` enters receive in preamble hunt. `cmd_sleep` enters deep sleep if `cfg_deep` is 1, and light sleep otherwise. When several commands arrive together, transmit beats receive and receive beats sleep, and no error is raised.
- R4: `cal_lost` seen in idle voids the calibration. The next `cmd_tx` or `cmd_rx` then spends CAL_CYCLES cycles in calibration before it enters the requested mode. After that, commands go direct again.
- R5: `phy_tx_sent` in transmit ends the transmission with cause good. The next mode is chosen as follows:
  - receive in preamble hunt if `cfg_rx_after_tx` is set;
  - otherwise sleep (deep if `cfg_deep`) if `cfg_sleep_after_tx` is set and `irq_pending` is low;
  - otherwise idle.
- R6: The receive sub-phase (`rx_phase`: 0 hunt, 1 delimiter search, 2 header, 3 payload) moves forward by one only on its own event: `phy_preamble` in 0, `phy_sfd` in 1, `phy_header` in 2. Any other event leaves it unchanged. It reads 0 outside receive.
- R7: Reception ends on `phy_frame_done` in phase 3 (cause good), or on `phy_error` or `phy_timeout` in any phase. If error and timeout arrive together, error wins. On the end, the sub-phase returns to 0. The block then goes to sleep (deep if `cfg_deep`) when `cfg_sleep_after_rx` is set and `irq_pending` is low, and to idle otherwise.
- R8: Every end of transmission or reception raises `done` for one cycle, together with `done_cause` (0 good, 1 error, 2 timeout). `done_cause` never reads 3 while `done` is high.
- R9: A command outside its legal mode is ignored, leaves the mode unchanged and raises `cmd_error` for one cycle. `cmd_wake` is legal only in the two sleeps. `cmd_tx`, `cmd_rx` and `cmd_sleep` are legal only in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wake | input | 1 | Host: leave sleep |
| cmd_tx | input | 1 | Host: start transmit |
| cmd_rx | input | 1 | Host: start receive |
| cmd_sleep | input | 1 | Host: go to sleep |
| cfg_sleep_after_tx | input | 1 | Auto-sleep after transmit |
| cfg_sleep_after_rx | input | 1 | Auto-sleep after receive |
| cfg_deep | input | 1 | Sleep entries choose deep sleep |
| cfg_rx_after_tx | input | 1 | Enter receive after transmit |
| phy_tx_sent | input | 1 | Frame transmission finished |
| phy_preamble | input | 1 | Preamble detected |
| phy_sfd | input | 1 | Frame delimiter found |
| phy_header | input | 1 | Header decoded |
| phy_frame_done | input | 1 | Payload received |
| phy_error | input | 1 | Receive error |
| phy_timeout | input | 1 | Receive timeout |
| irq_pending | input | 1 | Host interrupt pending |
| cal_lost | input | 1 | Synthesizer calibration no longer valid |
| mode | output | 3 | Current mode code |
| rx_phase | output | 2 | Receive sub-phase |
| osc_en | output | 1 | Crystal oscillator enable |
| synth_en | output | 1 | Synthesizer enable |
| cal_en | output | 1 | Loop calibration enable |
| cmd_error | output | 1 | Illegal command pulse |
| done | output | 1 | Transmit or receive end pulse |
| done_cause | output | 2 | Cause of the end |

## Verification
Several properties are checked on every cycle:
- the sub-phase reads zero outside receive and never moves backward except to zero;
- the cause code stays legal;
- no automatic sleep happens while an interrupt is pending;
- transmit is entered only from idle or calibration;
- the oscillator-start phase is not cut short.

Other behaviour can only be shown by the bench scenarios:
- the exact phase lengths;
- the choice of next mode for each configuration and interrupt combination;
- the rerouting through calibration after `cal_lost`;
- which commands count as illegal in which mode.

The bench sweeps all of these over a small timing configuration.

// File: rtl/radio_mode_seq.sv
module radio_mode_seq #(
  parameter int WAKE_CYCLES  = 4096,
  parameter int SYNTH_CYCLES = 64,
  parameter int CAL_CYCLES   = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wake,
  input  logic       cmd_tx,
  input  logic       cmd_rx,
  input  logic       cmd_sleep,
  input  logic       cfg_sleep_after_tx,
  input  logic       cfg_sleep_after_rx,
  input  logic       cfg_deep,
  input  logic       cfg_rx_after_tx,
  input  logic       phy_tx_sent,
  input  logic       phy_preamble,
  input  logic       phy_sfd,
  input  logic       phy_header,
  input  logic       phy_frame_done,
  input  logic       phy_error,
  input  logic       phy_timeout,
  input  logic       irq_pending,
  input  logic       cal_lost,
  output logic [2:0] mode,
  output logic [1:0] rx_phase,
  output logic       osc_en,
  output logic       synth_en,
  output logic       cal_en,
  output logic       cmd_error,
  output logic       done,
  output logic [1:0] done_cause
);
  localparam int MAXC = (WAKE_CYCLES > SYNTH_CYCLES) ?
                        ((WAKE_CYCLES > CAL_CYCLES) ? WAKE_CYCLES : CAL_CYCLES) :
                        ((SYNTH_CYCLES > CAL_CYCLES) ? SYNTH_CYCLES : CAL_CYCLES);
  localparam int CW = $clog2(MAXC + 1);

  localparam logic [2:0] M_SLEEP = 3'd0, M_DEEP = 3'd1, M_WAKE = 3'd2, M_SYN = 3'd3,
                         M_CAL = 3'd4, M_IDLE = 3'd5, M_TX = 3'd6, M_RX = 3'd7;
  localparam logic [1:0] C_GOOD = 2'd0, C_ERR = 2'd1, C_TMO = 2'd2;
  localparam logic [1:0] P_NONE = 2'd0, P_TX = 2'd1, P_RX = 2'd2;

  logic [CW-1:0] cnt;
  logic          cal_ok, cal_ok_n;
  logic [1:0]    pend, pend_n, phase_n, cause_n;
  logic [2:0]    mode_n;
  logic          done_n, illegal, asleep;

  wire [2:0] sleep_mode = cfg_deep ? M_DEEP : M_SLEEP;

  assign asleep   = (mode == M_SLEEP) || (mode == M_DEEP);
  assign osc_en   = !asleep;
  assign synth_en = (mode >= M_SYN);
  assign cal_en   = (mode == M_CAL);
  assign illegal  = (cmd_wake && !asleep) ||
                    ((cmd_tx || cmd_rx || cmd_sleep) && mode != M_IDLE);

  always_comb begin
    mode_n   = mode;
    phase_n  = rx_phase;
    cal_ok_n = cal_ok;
    pend_n   = pend;
    done_n   = 1'b0;
    cause_n  = done_cause;
    case (mode)
      M_SLEEP, M_DEEP: if (cmd_wake) mode_n = M_WAKE;
      M_WAKE: if (cnt == CW'(WAKE_CYCLES - 1)) mode_n = M_SYN;
      M_SYN:  if (cnt == CW'(SYNTH_CYCLES - 1)) mode_n = M_CAL;
      M_CAL: if (cnt == CW'(CAL_CYCLES - 1)) begin
        cal_ok_n = 1'b1;
        pend_n   = P_NONE;
        mode_n   = (pend == P_TX) ? M_TX : (pend == P_RX) ? M_RX : M_IDLE;
      end
      M_IDLE: begin
        if (cal_lost) cal_ok_n = 1'b0;
        if (cmd_tx || cmd_rx) begin
          if (cal_ok && !cal_lost) mode_n = cmd_tx ? M_TX : M_RX;
          else begin
            mode_n = M_CAL;
            pend_n = cmd_tx ? P_TX : P_RX;
          end
        end else if (cmd_sleep) mode_n = sleep_mode;
      end
      M_TX: if (phy_tx_sent) begin
        done_n  = 1'b1;
        cause_n = C_GOOD;
        if (cfg_rx_after_tx) mode_n = M_RX;
        else if (cfg_sleep_after_tx && !irq_pending) mode_n = sleep_mode;
        else mode_n = M_IDLE;
      end
      M_RX: begin
        if (phy_error || phy_timeout || (rx_phase == 2'd3 && phy_frame_done)) begin
          done_n  = 1'b1;
          cause_n = phy_error ? C_ERR : phy_timeout ? C_TMO : C_GOOD;
          phase_n = 2'd0;
          mode_n  = (cfg_sleep_after_rx && !irq_pending) ? sleep_mode : M_IDLE;
        end else if ((rx_phase == 2'd0 && phy_preamble) ||
                     (rx_phase == 2'd1 && phy_sfd) ||
                     (rx_phase == 2'd2 && phy_header))
          phase_n = rx_phase + 2'd1;
      end
      default: mode_n = M_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_SLEEP;
      cnt        <= '0;
      cal_ok     <= 1'b0;
      pend       <= P_NONE;
      rx_phase   <= 2'd0;
      done       <= 1'b0;
      done_cause <= C_GOOD;
      cmd_error  <= 1'b0;
    end else begin
      mode       <= mode_n;
      cnt        <= (mode_n != mode) ? '0 : cnt + 1'b1;
      cal_ok     <= cal_ok_n;
      pend       <= pend_n;
      rx_phase   <= phase_n;
      done       <= done_n;
      done_cause <= cause_n;
      cmd_error  <= illegal;
    end
  end

  a_r6_phase_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_RX) |-> (rx_phase == 2'd0));
  a_r6_phase_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_phase != 2'd0) |=> (rx_phase == 2'd0 || rx_phase >= $past(rx_phase)));
  a_r8_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cause != 2'd3));
  a_r5_no_sleep_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_TX || mode == M_RX) && irq_pending) |=> !(mode == M_SLEEP || mode == M_DEEP));
  a_r3_tx_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_TX) |=> (mode != M_TX || $past(mode) == M_IDLE || $past(mode) == M_CAL));
  a_r2_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_WAKE && cnt != CW'(WAKE_CYCLES - 1)) |=> (mode == M_WAKE));
endmodule

// File: tb/test_radio_mode_seq.sv
module test_radio_mode_seq;
  localparam int W = 3, S = 2, C = 2;
  localparam int SLEEP = 0, DEEP = 1, WAKE = 2, SYN = 3, CAL = 4, IDLE = 5, TX = 6, RX = 7;

  logic clk = 0, rst_n = 0;
  logic cmd_wake = 0, cmd_tx = 0, cmd_rx = 0, cmd_sleep = 0;
  logic cfg_sleep_after_tx = 0, cfg_sleep_after_rx = 0, cfg_deep = 0, cfg_rx_after_tx = 0;
  logic phy_tx_sent = 0, phy_preamble = 0, phy_sfd = 0, phy_header = 0;
  logic phy_frame_done = 0, phy_error = 0, phy_timeout = 0, irq_pending = 0, cal_lost = 0;
  logic [2:0] mode;
  logic [1:0] rx_phase, done_cause;
  logic osc_en, synth_en, cal_en, cmd_error, done;

  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  radio_mode_seq #(.WAKE_CYCLES(W), .SYNTH_CYCLES(S), .CAL_CYCLES(C)) i_radio_mode_seq (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_in();
    cmd_wake = 0; cmd_tx = 0; cmd_rx = 0; cmd_sleep = 0; phy_tx_sent = 0;
    phy_preamble = 0; phy_sfd = 0; phy_header = 0; phy_frame_done = 0;
    phy_error = 0; phy_timeout = 0; cal_lost = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic bring_up(int from);
    cmd_wake = 1; tick(); clear_in();
    for (int k = 0; k < W; k++) begin
      chk("R2 wake", mode, WAKE); chk("R1 osc_en", osc_en, 1); chk("R1 synth_en", synth_en, 0); tick();
    end
    for (int k = 0; k < S; k++) begin chk("R2 synth", mode, SYN); chk("R1 synth_en", synth_en, 1); tick(); end
    for (int k = 0; k < C; k++) begin chk("R2 cal", mode, CAL); chk("R1 cal_en", cal_en, 1); tick(); end
    chk("R2 idle", mode, IDLE); chk("R1 cal_en", cal_en, 0);
  endtask

  task automatic run_tx(bit rxa, bit sl, bit dp, bit irq);
    int expm;
    do_reset(); bring_up(SLEEP);
    cmd_tx = 1; tick(); clear_in(); chk("R3 tx entry", mode, TX);
    cfg_rx_after_tx = rxa; cfg_sleep_after_tx = sl; cfg_deep = dp; irq_pending = irq;
    phy_tx_sent = 1; tick(); clear_in();
    expm = rxa ? RX : (sl && !irq) ? (dp ? DEEP : SLEEP) : IDLE;
    chk("R5 next mode", mode, expm);
    chk("R8 done", done, 1); chk("R8 cause good", done_cause, 0);
    chk("R6 phase after tx", rx_phase, 0);
    tick(); chk("R8 done one cycle", done, 0);
    cfg_rx_after_tx = 0; cfg_sleep_after_tx = 0; cfg_deep = 0; irq_pending = 0;
  endtask

  task automatic run_rx(int stop, int kind, bit sl, bit dp, bit irq);
    int expm;
    do_reset(); bring_up(SLEEP);
    cmd_rx = 1; tick(); clear_in(); chk("R3 rx entry", mode, RX); chk("R6 hunt", rx_phase, 0);
    phy_header = 1; phy_frame_done = 1; tick(); clear_in(); chk("R6 out of order", rx_phase, 0);
    chk("R7 no early end", done, 0);
    for (int p = 0; p < stop; p++) begin
      phy_preamble = (p == 0); phy_sfd = (p == 1); phy_header = (p == 2); tick(); clear_in();
      chk("R6 advance", rx_phase, p + 1);
    end
    cfg_sleep_after_rx = sl; cfg_deep = dp; irq_pending = irq;
    if (kind == 0) phy_frame_done = 1;
    else if (kind == 1) begin phy_error = 1; phy_timeout = (stop == 1); end
    else phy_timeout = 1;
    tick(); clear_in();
    expm = (sl && !irq) ? (dp ? DEEP : SLEEP) : IDLE;
    chk("R7 next mode", mode, expm); chk("R7 phase cleared", rx_phase, 0);
    chk("R8 done", done, 1); chk("R8 cause", done_cause, kind);
    chk("R1 osc_en", osc_en, (expm == IDLE) ? 1 : 0);
    tick(); chk("R8 done one cycle", done, 0);
    cfg_sleep_after_rx = 0; cfg_deep = 0; irq_pending = 0;
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset mode", mode, SLEEP); chk("R1 osc_en", osc_en, 0); chk("R1 synth_en", synth_en, 0);
    chk("R1 cal_en", cal_en, 0); chk("R1 done", done, 0); chk("R1 cmd_error", cmd_error, 0);
    chk("R1 phase", rx_phase, 0);

    cmd_tx = 1; tick(); clear_in();
    chk("R9 tx in sleep", cmd_error, 1); chk("R9 mode kept", mode, SLEEP);
    tick(); chk("R9 pulse one cycle", cmd_error, 0);

    bring_up(SLEEP);
    cmd_wake = 1; tick(); clear_in(); chk("R9 wake in idle", cmd_error, 1); chk("R9 mode kept", mode, IDLE);
    cmd_tx = 1; cmd_rx = 1; cmd_sleep = 1; tick(); clear_in();
    chk("R3 priority", mode, TX); chk("R3 no error", cmd_error, 0);
    cmd_rx = 1; tick(); clear_in(); chk("R9 rx in tx", cmd_error, 1); chk("R9 mode kept", mode, TX);
    phy_tx_sent = 1; tick(); clear_in(); chk("R5 idle", mode, IDLE);

    cmd_rx = 1; cmd_sleep = 1; tick(); clear_in(); chk("R3 rx over sleep", mode, RX);
    phy_timeout = 1; tick(); clear_in(); chk("R7 timeout end", mode, IDLE);

    cal_lost = 1; tick(); clear_in(); chk("R4 stays idle", mode, IDLE);
    cmd_rx = 1; tick(); clear_in();
    for (int k = 0; k < C; k++) begin chk("R4 recal", mode, CAL); tick(); end
    chk("R4 rx after recal", mode, RX); chk("R4 phase", rx_phase, 0);
    phy_error = 1; tick(); clear_in(); chk("R7 error end", mode, IDLE);
    cmd_tx = 1; tick(); clear_in(); chk("R4 direct tx again", mode, TX);
    phy_tx_sent = 1; tick(); clear_in();

    cal_lost = 1; cmd_tx = 1; tick(); clear_in(); chk("R4 same-cycle lost", mode, CAL);
    tick(); tick(); chk("R4 tx after recal", mode, TX);
    phy_tx_sent = 1; tick(); clear_in();

    cfg_deep = 1; cmd_sleep = 1; tick(); clear_in(); cfg_deep = 0;
    chk("R3 deep sleep", mode, DEEP); chk("R1 osc off", osc_en, 0);
    cmd_sleep = 1; tick(); clear_in(); chk("R9 sleep in deep", cmd_error, 1); chk("R9 mode kept", mode, DEEP);
    cmd_wake = 1; tick(); clear_in(); chk("R2 wake from deep", mode, WAKE);
    cmd_sleep = 1; tick(); clear_in(); chk("R9 sleep in wake", cmd_error, 1); chk("R9 mode kept", mode, WAKE);

    for (int v = 0; v < 16; v++) run_tx(v[3], v[2], v[1], v[0]);
    for (int v = 0; v < 8; v++) begin
      run_rx(3, 0, v[2], v[1], v[0]);
      for (int p = 0; p < 4; p++) begin
        run_rx(p, 1, v[2], v[1], v[0]);
        run_rx(p, 2, v[2], v[1], v[0]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule